// File: doc/BRIEF.md
# Coprocessor Error Interrupt Logic

This block sits between a processor's floating-point error output and the system interrupt controller. It provides the legacy way of reporting numeric errors. When the processor raises its active-low error signal, the block raises an internal interrupt request line. Software services that interrupt and then writes to a dedicated clear port. That write drops the interrupt request and drives an active-low ignore-numeric-error signal back to the processor. The ignore signal stays asserted only while the processor keeps its error signal active.

The error input comes from another timing domain. It passes through a synchronizer before any decision is made on it. A single enable bit gates the whole function: while the bit is clear, both outputs are inactive and the internal state returns to idle. Address decoding of the clear port, the interrupt controller and access to the configuration register all lie outside the block. The block sees only a decoded one-cycle write strobe and a level enable.

Top module: `coproc_err_irq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `irq_req` is 0 and `ignore_err_n` is 1.
- R2: With `cfg_enable` at 1 and no error pending, `fp_err_n` going low makes `irq_req` rise after the third rising clock edge following the change, and not earlier. Two synchronizer flops and one state flop account for the three edges.
- R3: A `clr_port_wr` pulse sampled at a rising edge while `irq_req` is 1 and the synchronized error is still active makes `irq_req` 0 and `ignore_err_n` 0 directly after that edge.
- R4: `ignore_err_n` stays 0 for as long as `fp_err_n` stays low. It returns to 1 after the third rising edge following `fp_err_n` going high.
- R5: `irq_req` and an active `ignore_err_n` (0) never occur together. `ignore_err_n` is 0 only when the synchronized error was active on the previous cycle.
- R6: A `clr_port_wr` pulse while no error is pending (`irq_req` 1 never reached) changes neither output.
- R7: If `fp_err_n` returns high before any clear write, `irq_req` falls after the third rising edge following that change, and `ignore_err_n` stays 1.
- R8: While `cfg_enable` is 0, `irq_req` is 0 and `ignore_err_n` is 1 in the same cycle, whatever the other inputs do. After `cfg_enable` returns to 1 with the error still active, `irq_req` rises after the next rising edge.
- R9: After `fp_err_n` has gone high and the outputs have gone idle, a new low level on `fp_err_n` raises `irq_req` again, and the request, clear and ignore cycle repeats.
- R10: Further `clr_port_wr` pulses while `ignore_err_n` is 0 leave it at 0 and keep `irq_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Function enable; 0 forces both outputs inactive |
| fp_err_n | input | 1 | Processor floating-point error, active low, asynchronous |
| clr_port_wr | input | 1 | One-cycle strobe for a decoded write to the clear port |
| irq_req | output | 1 | Internal interrupt request level, active high |
| ignore_err_n | output | 1 | Ignore-numeric-error to the processor, active low |

## Verification
A level change on `fp_err_n` reaches the outputs after three rising edges. The bench changes that input just after a falling edge. It checks that the old value still holds after two edges and that the new value is present after the third. A clear-port write and a change of enable act within one edge or combinationally, so they are checked right after the edge that samples them, or in the same half cycle. A long pseudo-random sweep drives all three inputs. It compares both outputs every cycle, at the falling edge, against a cycle-exact model the bench keeps from these latencies.

// File: rtl/cerr_pkg.sv
package cerr_pkg;
   typedef enum logic [1:0] {
      CE_IDLE   = 2'd0,
      CE_IRQ    = 2'd1,
      CE_IGNORE = 2'd2
   } cerr_state_t;
endpackage

// File: rtl/cerr_sync.sv
module cerr_sync #(
   parameter int STAGES        = 2,
   parameter bit IN_ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic active_out
);
   localparam int LAST = STAGES - 1;

   logic             level_in;
   logic [LAST:0]    chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cerr_sync: STAGES must be at least 2");
      end
      if (IN_ACTIVE_LOW) begin : g_inv
         assign level_in = ~raw_in;
      end else begin : g_pass
         assign level_in = raw_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[LAST-1:0], level_in};
      end
   end

   assign active_out = chain_q[LAST];
endmodule

// File: rtl/cerr_fsm.sv
module cerr_fsm
   import cerr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  logic        err_active,
   input  logic        clr_wr,
   output cerr_state_t state
);
   cerr_state_t state_d;

   always_comb begin
      state_d = state;
      if (!enable) begin
         state_d = CE_IDLE;
      end else begin
         unique case (state)
            CE_IDLE:   if (err_active) state_d = CE_IRQ;
            CE_IRQ: begin
               if (!err_active)  state_d = CE_IDLE;
               else if (clr_wr)  state_d = CE_IGNORE;
            end
            CE_IGNORE: if (!err_active) state_d = CE_IDLE;
            default:   state_d = CE_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= CE_IDLE;
      else        state <= state_d;
   end
endmodule

// File: rtl/cerr_outdrv.sv
module cerr_outdrv
   import cerr_pkg::*;
#(
   parameter bit IGN_ACTIVE_LOW = 1'b1
) (
   input  logic        enable,
   input  cerr_state_t state,
   output logic        irq_level,
   output logic        ignore_pin
);
   logic ignore_level;

   assign irq_level    = enable && (state == CE_IRQ);
   assign ignore_level = enable && (state == CE_IGNORE);

   generate
      if (IGN_ACTIVE_LOW) begin : g_low
         assign ignore_pin = ~ignore_level;
      end else begin : g_high
         assign ignore_pin = ignore_level;
      end
   endgenerate
endmodule

// File: rtl/coproc_err_irq.sv
module coproc_err_irq
   import cerr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_enable,
   input  logic fp_err_n,
   input  logic clr_port_wr,
   output logic irq_req,
   output logic ignore_err_n
);
   logic        err_sync;
   cerr_state_t cur_state;

   cerr_sync #(.STAGES(SYNC_STAGES), .IN_ACTIVE_LOW(1'b1)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_in     (fp_err_n),
      .active_out (err_sync)
   );

   cerr_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cfg_enable),
      .err_active (err_sync),
      .clr_wr     (clr_port_wr),
      .state      (cur_state)
   );

   cerr_outdrv #(.IGN_ACTIVE_LOW(1'b1)) u_out (
      .enable     (cfg_enable),
      .state      (cur_state),
      .irq_level  (irq_req),
      .ignore_pin (ignore_err_n)
   );
endmodule

// File: rtl/coproc_err_irq_chk.sv
module coproc_err_irq_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_enable,
   input logic clr_port_wr,
   input logic err_sync,
   input logic irq_req,
   input logic ignore_err_n
);
   // R8: disabled function keeps both outputs inactive
   p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |-> (!irq_req && ignore_err_n));

   // R5: request and ignore never together
   p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req && !ignore_err_n));

   // R5: ignore only follows an active synchronized error
   p_ignore_needs_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ignore_err_n |-> $past(err_sync));

   // R2: pending error in idle raises the request
   p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable && err_sync && !irq_req && ignore_err_n) |=> (irq_req || !cfg_enable));

   // R3: clear write hands over to ignore
   p_handover_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable && irq_req && err_sync && clr_port_wr) |=>
         (!cfg_enable || (!irq_req && !ignore_err_n)));

   // R4: ignore held while the error persists
   p_ignore_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ignore_err_n && err_sync) |=> (!ignore_err_n || !cfg_enable));

   // R6: write with no error pending does nothing
   p_idle_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_port_wr && !err_sync && ignore_err_n) |=> ignore_err_n);
endmodule

bind coproc_err_irq coproc_err_irq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_enable   (cfg_enable),
   .clr_port_wr  (clr_port_wr),
   .err_sync     (err_sync),
   .irq_req      (irq_req),
   .ignore_err_n (ignore_err_n)
);

// File: tb/coproc_err_irq_tb.sv
`timescale 1ns/1ps
module coproc_err_irq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable = 1'b0;
   logic fp_err_n = 1'b1;
   logic clr_port_wr = 1'b0;
   logic irq_req, ignore_err_n;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   coproc_err_irq u_dut (.*);

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(string req, logic e_irq, logic e_ign_n);
      checks++;
      if (irq_req !== e_irq || ignore_err_n !== e_ign_n) begin
         errors++;
         $display("FAIL %s: irq_req=%b ignore_err_n=%b expected irq_req=%b ignore_err_n=%b",
                  req, irq_req, ignore_err_n, e_irq, e_ign_n);
      end
   endtask

   task automatic pulse_wr();
      clr_port_wr = 1'b1;
      tick();
      clr_port_wr = 1'b0;
   endtask

   // cycle-exact reference: input latency three edges, writes and enable act at once
   logic m_s1, m_s2;
   logic [1:0] m_st;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 1'b0; m_s2 <= 1'b0; m_st <= 2'd0;
      end else begin
         m_s1 <= ~fp_err_n;
         m_s2 <= m_s1;
         if (!cfg_enable) m_st <= 2'd0;
         else if (m_st == 2'd0) m_st <= m_s2 ? 2'd1 : 2'd0;
         else if (!m_s2) m_st <= 2'd0;
         else if (m_st == 2'd1 && clr_port_wr) m_st <= 2'd2;
      end
   end

   initial begin
      tick(2);
      expect_out("R1 in reset", 1'b0, 1'b1);
      rst_n = 1'b1;
      tick();
      expect_out("R1 after release", 1'b0, 1'b1);
      cfg_enable = 1'b1;

      // R6: write with no error
      pulse_wr();
      tick(2);
      expect_out("R6 idle write", 1'b0, 1'b1);

      // R2: exact latency of three edges
      fp_err_n = 1'b0;
      tick(2);
      expect_out("R2 not before third edge", 1'b0, 1'b1);
      tick();
      expect_out("R2 request raised", 1'b1, 1'b1);

      // R3: handover
      pulse_wr();
      expect_out("R3 handover", 1'b0, 1'b0);

      // R10: more writes while ignoring
      pulse_wr();
      pulse_wr();
      expect_out("R10 repeated writes", 1'b0, 1'b0);

      // R4: held, then released after three edges
      tick(5);
      expect_out("R4 held", 1'b0, 1'b0);
      fp_err_n = 1'b1;
      tick(2);
      expect_out("R4 held until third edge", 1'b0, 1'b0);
      tick();
      expect_out("R4 released", 1'b0, 1'b1);

      // R9: repeat cycle
      fp_err_n = 1'b0;
      tick(3);
      expect_out("R9 request again", 1'b1, 1'b1);
      pulse_wr();
      expect_out("R9 ignore again", 1'b0, 1'b0);
      fp_err_n = 1'b1;
      tick(3);
      expect_out("R9 idle again", 1'b0, 1'b1);

      // R7: error withdrawn before the write
      fp_err_n = 1'b0;
      tick(3);
      expect_out("R7 request", 1'b1, 1'b1);
      fp_err_n = 1'b1;
      tick(2);
      expect_out("R7 request still up", 1'b1, 1'b1);
      tick();
      expect_out("R7 request dropped", 1'b0, 1'b1);
      pulse_wr();
      expect_out("R6 late write no effect", 1'b0, 1'b1);

      // R8: enable gating
      fp_err_n = 1'b0;
      tick(3);
      pulse_wr();
      expect_out("R8 ignoring before disable", 1'b0, 1'b0);
      cfg_enable = 1'b0;
      #0.5;
      expect_out("R8 disable immediate", 1'b0, 1'b1);
      tick(3);
      pulse_wr();
      expect_out("R8 disabled write", 1'b0, 1'b1);
      cfg_enable = 1'b1;
      tick();
      expect_out("R8 re-enable request", 1'b1, 1'b1);
      fp_err_n = 1'b1;
      tick(4);

      // sweep: pseudo-random inputs against the reference, R2-R10
      begin
         logic [15:0] lfsr = 16'hACE1;
         for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cfg_enable = (lfsr[2:0] != 3'd0);
            if (lfsr[7:4] == 4'd0) fp_err_n = ~fp_err_n;
            clr_port_wr = (lfsr[9:8] == 2'd0);
            tick();
            expect_out("R2-sweep model", cfg_enable && m_st == 2'd1,
                       !(cfg_enable && m_st == 2'd2));
         end
         clr_port_wr = 1'b0;
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: expected=done actual=timeout");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule